// File: doc/BRIEF.md
# Synchronous DRAM Start-Up Command Sequencer

This block drives the command, address, bank, clock-enable and mask pins of a synchronous DRAM from reset until the device is ready for normal traffic. It walks through a fixed series of phases. First comes a long stabilization pause in which only no-operation commands are issued while clock-enable and the data mask stay high. Then it closes every bank, issues a train of auto-refresh commands and loads the mode register. A settle delay follows, after which a done flag is raised. The system controller then takes over the command bus.

The clock period and each wait are parameters given in time units. They are converted to whole clock cycles by rounding up, so the block can be retimed for another clock by changing one parameter. The value written into the mode register comes from an input and is captured when the load command goes out. Normal access scheduling, periodic refresh and power management are left to the logic that follows.

Top module: `memStartupSeq`

## Requirements
- R1: While reset is asserted the outputs are: chip select low, RAS, CAS and WE high (a no-operation), clock-enable high, data mask high, address and bank zero, done low.
- R2: Only no-operation commands are driven before the precharge-all command. The precharge-all is the first other command, and it is driven in the cycle after the PAUSE_CYC-th rising clock edge following reset release.
- R3: Precharge-all is encoded as chip select, RAS and WE low with CAS high, address bit 10 high and all other address bits and the bank zero. It is driven exactly once and lasts one cycle.
- R4: Exactly REFRESH_COUNT auto-refresh commands follow (chip select, RAS and CAS low, WE high). The first comes RP_CYC cycles after the precharge-all, and each later one comes RC_CYC cycles after the previous refresh. Each lasts one cycle.
- R5: One mode-load command (chip select, RAS, CAS and WE all low) is driven RC_CYC cycles after the last refresh. Its address is the mode input in bits 9:0 with bits 12:10 zero, and its bank is zero. The mode input is captured only in that cycle, so later changes leave the address at zero.
- R6: Every wait in cycles is max(1, ceil(wait_ns * 1000 / CLK_PERIOD_PS)). For example, 65 ns at 10 ns gives 7 cycles, and 20 ns at 7.5 ns gives 3.
- R7: Clock-enable is high in every cycle from reset onward, so it is high before and during the mode load.
- R8: Only no-operation commands follow the mode load. Done rises exactly RSC_CYC cycles after the mode-load cycle and then stays high until reset. The data mask is high while done is low and low once done is high.
- R9: Asserting reset partway through the series returns the block to its R1 state, and after release the whole series restarts with the full pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeValue | input | 10 | Value loaded into the memory mode register |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memCke | output | 1 | Clock enable |
| memDqm | output | 1 | Data mask |
| memAddr | output | 13 | Address lines |
| memBank | output | 2 | Bank select lines |
| initDone | output | 1 | Start-up series complete |

## Verification
A wrong phase or a miscounted wait inside the block shows up at the pins as a command of the wrong kind or one that lands on the wrong cycle. The bench times every non-idle command against the previous one and flags a misplacement in the cycle where it occurs. A refresh counter that is off by one shows as a missing or extra refresh, or as a mode load after too few refreshes, and this is seen at the mode-load cycle. A stuck done or mask, or a mode value captured at the wrong time, is visible within a few cycles after done rises.

// File: rtl/memStartupPkg.sv
package memStartupPkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRECHARGE_ALL,
    CMD_REFRESH,
    CMD_LOAD_MODE
  } initCmd_e;

  typedef enum logic [1:0] {
    WAIT_PAUSE,
    WAIT_RP,
    WAIT_RC,
    WAIT_RSC
  } waitSel_e;

  // Strobes passed from the control FSM to the datapath each cycle
  typedef struct packed {
    logic     issue;
    initCmd_e cmd;
    logic     loadWait;
    waitSel_e waitSel;
    logic     setDone;
  } seqStrobes_t;

  // Convert a wait in ns to clock cycles, rounding up, at least one cycle
  function automatic int cyclesFor(input int waitNs, input int periodPs);
    int c;
    c = (waitNs * 1000 + periodPs - 1) / periodPs;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/memStartupCtrl.sv
module memStartupCtrl
  import memStartupPkg::*;
#(
  parameter int REFRESH_COUNT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        waitZero,
  output seqStrobes_t strobes
);

  localparam int REF_W = $clog2(REFRESH_COUNT + 1);

  typedef enum logic [2:0] {
    S_PAUSE,
    S_WAIT_RP,
    S_WAIT_RC,
    S_WAIT_RSC,
    S_DONE
  } seqState_e;

  seqState_e        state, nextState;
  logic [REF_W-1:0] refCnt, refNext;

  always_comb begin
    nextState        = state;
    refNext          = refCnt;
    strobes          = '0;
    strobes.cmd      = CMD_NOP;
    strobes.waitSel  = WAIT_PAUSE;
    case (state)
      S_PAUSE: if (waitZero) begin
        strobes.issue    = 1'b1;
        strobes.cmd      = CMD_PRECHARGE_ALL;
        strobes.loadWait = 1'b1;
        strobes.waitSel  = WAIT_RP;
        nextState        = S_WAIT_RP;
      end
      S_WAIT_RP: if (waitZero) begin
        strobes.issue    = 1'b1;
        strobes.cmd      = CMD_REFRESH;
        strobes.loadWait = 1'b1;
        strobes.waitSel  = WAIT_RC;
        refNext          = REF_W'(1);
        nextState        = S_WAIT_RC;
      end
      S_WAIT_RC: if (waitZero) begin
        strobes.issue    = 1'b1;
        strobes.loadWait = 1'b1;
        if (refCnt == REF_W'(REFRESH_COUNT)) begin
          strobes.cmd     = CMD_LOAD_MODE;
          strobes.waitSel = WAIT_RSC;
          nextState       = S_WAIT_RSC;
        end else begin
          strobes.cmd     = CMD_REFRESH;
          strobes.waitSel = WAIT_RC;
          refNext         = refCnt + REF_W'(1);
        end
      end
      S_WAIT_RSC: if (waitZero) begin
        strobes.setDone = 1'b1;
        nextState       = S_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_PAUSE;
      refCnt <= '0;
    end else begin
      state  <= nextState;
      refCnt <= refNext;
    end
  end

  // R4: the mode load only goes out once the full refresh train is done
  assert_mode_after_refreshes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && strobes.cmd == CMD_LOAD_MODE) |-> (refCnt == REF_W'(REFRESH_COUNT)));

  // R3: the precharge-all is issued only from the pause phase
  assert_single_precharge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && strobes.cmd == CMD_PRECHARGE_ALL) |-> (state == S_PAUSE));

endmodule

// File: rtl/memStartupDatapath.sv
module memStartupDatapath
  import memStartupPkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int CNT_W     = 16,
  parameter int PAUSE_CYC = 2,
  parameter int RP_CYC    = 2,
  parameter int RC_CYC    = 7,
  parameter int RSC_CYC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [AP_BIT-1:0] modeValue,
  output logic              waitZero,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic              memCke,
  output logic              memDqm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BANK_W-1:0] memBank,
  output logic              initDone
);

  localparam int HI_W = ADDR_W - AP_BIT;

  logic [CNT_W-1:0] waitCnt, loadValue;

  assign waitZero = (waitCnt == '0);

  always_comb begin
    case (strobes.waitSel)
      WAIT_RP:  loadValue = CNT_W'(RP_CYC - 1);
      WAIT_RC:  loadValue = CNT_W'(RC_CYC - 1);
      WAIT_RSC: loadValue = CNT_W'(RSC_CYC - 1);
      default:  loadValue = CNT_W'(PAUSE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 waitCnt <= CNT_W'(PAUSE_CYC - 1);
    else if (strobes.loadWait) waitCnt <= loadValue;
    else if (!waitZero)        waitCnt <= waitCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {memCsN, memRasN, memCasN, memWeN} <= 4'b0111;
      memAddr  <= '0;
      memBank  <= '0;
      memCke   <= 1'b1;
      memDqm   <= 1'b1;
      initDone <= 1'b0;
    end else begin
      {memCsN, memRasN, memCasN, memWeN} <= 4'b0111;
      memAddr <= '0;
      memBank <= '0;
      memCke  <= 1'b1;
      if (strobes.issue) begin
        case (strobes.cmd)
          CMD_PRECHARGE_ALL: begin
            {memCsN, memRasN, memCasN, memWeN} <= 4'b0010;
            memAddr <= ADDR_W'(1) << AP_BIT;
          end
          CMD_REFRESH:
            {memCsN, memRasN, memCasN, memWeN} <= 4'b0001;
          CMD_LOAD_MODE: begin
            {memCsN, memRasN, memCasN, memWeN} <= 4'b0000;
            memAddr <= {{HI_W{1'b0}}, modeValue};
          end
          default: ;
        endcase
      end
      if (strobes.setDone) begin
        initDone <= 1'b1;
        memDqm   <= 1'b0;
      end
    end
  end

  // R3: no command leaves before the running wait has expired
  assert_wait_honoured_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issue |-> waitZero);

  // R8: done holds once raised
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R8: the bus stays idle once done is raised
  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> ({memCsN, memRasN, memCasN, memWeN} == 4'b0111));

  // R5: a mode load on the pins carries zero bank and zero upper address bits
  assert_mode_fields_R5: assert property (@(posedge clk) disable iff (!rstN)
    ({memCsN, memRasN, memCasN, memWeN} == 4'b0000) |->
      (memBank == '0 && memAddr[ADDR_W-1:AP_BIT] == '0));

endmodule

// File: rtl/memStartupSeq.sv
module memStartupSeq
  import memStartupPkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int PAUSE_NS      = 200000,
  parameter int TRP_NS        = 20,
  parameter int TRC_NS        = 65,
  parameter int TRSC_NS       = 15,
  parameter int REFRESH_COUNT = 8,
  parameter int ADDR_W        = 13,
  parameter int BANK_W        = 2,
  parameter int AP_BIT        = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AP_BIT-1:0] modeValue,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic              memCke,
  output logic              memDqm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BANK_W-1:0] memBank,
  output logic              initDone
);

  localparam int PAUSE_CYC = cyclesFor(PAUSE_NS, CLK_PERIOD_PS);
  localparam int RP_CYC    = cyclesFor(TRP_NS, CLK_PERIOD_PS);
  localparam int RC_CYC    = cyclesFor(TRC_NS, CLK_PERIOD_PS);
  localparam int RSC_CYC   = cyclesFor(TRSC_NS, CLK_PERIOD_PS);
  localparam int MAX_A     = (PAUSE_CYC > RP_CYC) ? PAUSE_CYC : RP_CYC;
  localparam int MAX_B     = (RC_CYC > RSC_CYC) ? RC_CYC : RSC_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seqStrobes_t strobes;
  logic        waitZero;

  memStartupCtrl #(
    .REFRESH_COUNT(REFRESH_COUNT)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .waitZero(waitZero),
    .strobes (strobes)
  );

  memStartupDatapath #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .AP_BIT   (AP_BIT),
    .CNT_W    (CNT_W),
    .PAUSE_CYC(PAUSE_CYC),
    .RP_CYC   (RP_CYC),
    .RC_CYC   (RC_CYC),
    .RSC_CYC  (RSC_CYC)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .modeValue(modeValue),
    .waitZero (waitZero),
    .memCsN   (memCsN),
    .memRasN  (memRasN),
    .memCasN  (memCasN),
    .memWeN   (memWeN),
    .memCke   (memCke),
    .memDqm   (memDqm),
    .memAddr  (memAddr),
    .memBank  (memBank),
    .initDone (initDone)
  );

endmodule

// File: tb/test_memStartupSeq.sv
`timescale 1ns/1ps
module test_memStartupSeq;

  // Expected cycle counts worked out by hand from R6:
  // instance 0 at 10 ns: pause 200 us -> 20000, 20 ns -> 2, 65 ns -> 7, 15 ns -> 2
  // instance 1 at 7.5 ns: pause 1 us -> 134, 20 ns -> 3, 65 ns -> 9, 15 ns -> 2
  localparam int NUM_REF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0]  modeVal [2];
  logic        csN [2], rasN [2], casN [2], weN [2], cke [2], dqm [2], done [2];
  logic [12:0] addr [2];
  logic [1:0]  bank [2];

  int checks = 0;
  int errors = 0;

  localparam int K_NOP = 0, K_PRE = 1, K_REF = 2, K_MRS = 3, K_BAD = 4;

  always #5 clk = ~clk;

  memStartupSeq i_memStartupSeq (
    .clk(clk), .rstN(rstN), .modeValue(modeVal[0]),
    .memCsN(csN[0]), .memRasN(rasN[0]), .memCasN(casN[0]), .memWeN(weN[0]),
    .memCke(cke[0]), .memDqm(dqm[0]), .memAddr(addr[0]), .memBank(bank[0]),
    .initDone(done[0])
  );

  memStartupSeq #(
    .CLK_PERIOD_PS(7500), .PAUSE_NS(1000)
  ) i_memStartupSeq_fast (
    .clk(clk), .rstN(rstN), .modeValue(modeVal[1]),
    .memCsN(csN[1]), .memRasN(rasN[1]), .memCasN(casN[1]), .memWeN(weN[1]),
    .memCke(cke[1]), .memDqm(dqm[1]), .memAddr(addr[1]), .memBank(bank[1]),
    .initDone(done[1])
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int decode(input int idx);
    case ({csN[idx], rasN[idx], casN[idx], weN[idx]})
      4'b0111: return K_NOP;
      4'b0010: return K_PRE;
      4'b0001: return K_REF;
      4'b0000: return K_MRS;
      default: return K_BAD;
    endcase
  endfunction

  // R1 / R7: outputs while reset is held
  task automatic checkResetState(input int idx, input string req);
    check(decode(idx) == K_NOP, req, "reset command is NOP", decode(idx), K_NOP);
    check(cke[idx] == 1'b1, "R7", "reset cke", int'(cke[idx]), 1);
    check(dqm[idx] == 1'b1 && done[idx] == 1'b0, req, "reset dqm/done",
          int'({dqm[idx], done[idx]}), 2);
    check(addr[idx] == 13'd0 && bank[idx] == 2'd0, req, "reset addr/bank",
          int'({bank[idx], addr[idx]}), 0);
  endtask

  // Watches one full start-up series; called at the negedge where reset is released
  task automatic watchSequence(input int idx, input int pCyc, input int rp,
                               input int rc, input int rsc, input logic [9:0] mode);
    int lastAt = -1, mrsAt = -1, doneAt = -1;
    int nPre = 0, nRef = 0, nMrs = 0, nBad = 0;
    bit ckeBad = 0, dqmBad = 0, doneDrop = 0, lateCmd = 0, addrBad = 0;
    int limit = pCyc + rp + rc * NUM_REF + rsc + 40;
    for (int i = 1; i <= limit; i++) begin
      int k;
      @(negedge clk);
      k = decode(idx);
      if (cke[idx] !== 1'b1) ckeBad = 1;
      if (dqm[idx] !== !done[idx]) dqmBad = 1;
      if (doneAt >= 0 && done[idx] !== 1'b1) doneDrop = 1;
      if (done[idx] === 1'b1 && doneAt < 0) doneAt = i;
      if (doneAt >= 0 && i == doneAt + 2) modeVal[idx] = ~mode;
      if (doneAt >= 0 && i > doneAt + 2 && addr[idx] != 13'd0) addrBad = 1;
      if (k != K_NOP) begin
        if (mrsAt >= 0) lateCmd = 1;
        case (k)
          K_PRE: begin
            nPre++;
            check(i == pCyc && nRef == 0, "R2", "precharge cycle", i, pCyc);
            check(addr[idx] == 13'h0400 && bank[idx] == 2'd0, "R3", "precharge addr",
                  int'(addr[idx]), 'h400);
          end
          K_REF: begin
            nRef++;
            if (nRef == 1)
              check(nPre == 1 && i - lastAt == rp, "R4", "first refresh gap", i - lastAt, rp);
            else if (i - lastAt != rc)
              check(0, "R4", "refresh gap", i - lastAt, rc);
          end
          K_MRS: begin
            nMrs++;
            mrsAt = i;
            check(i - lastAt == rc, "R5", "mode load gap", i - lastAt, rc);
            check(nRef == NUM_REF, "R4", "refreshes before mode load", nRef, NUM_REF);
            check(addr[idx] == {3'b000, mode}, "R5", "mode load addr",
                  int'(addr[idx]), int'({3'b000, mode}));
            check(bank[idx] == 2'd0, "R5", "mode load bank", int'(bank[idx]), 0);
          end
          default: nBad++;
        endcase
        lastAt = i;
      end
      if (doneAt >= 0 && i >= doneAt + 20) break;
    end
    check(nBad == 0, "R3", "unexpected command encodings", nBad, 0);
    check(nPre == 1, "R3", "precharge count", nPre, 1);
    check(nRef == NUM_REF, "R4", "refresh count", nRef, NUM_REF);
    check(nMrs == 1, "R5", "mode load count", nMrs, 1);
    check(doneAt >= 0 && doneAt - mrsAt == rsc, "R8", "done delay", doneAt - mrsAt, rsc);
    check(!doneDrop, "R8", "done stays high", int'(doneDrop), 0);
    check(!lateCmd, "R8", "commands after mode load", int'(lateCmd), 0);
    check(!dqmBad, "R8", "dqm follows done", int'(dqmBad), 0);
    check(!ckeBad, "R7", "cke always high", int'(ckeBad), 0);
    check(!addrBad, "R5", "mode change after load ignored", int'(addrBad), 0);
  endtask

  task automatic scenarioReset;
    repeat (4) @(negedge clk);
    checkResetState(0, "R1");
    checkResetState(1, "R1");
  endtask

  // R6 default timing on the main instance
  task automatic scenarioMainSeries;
    modeVal[0] = 10'h032;
    rstN = 1'b1;
    watchSequence(0, 20000, 2, 7, 2, 10'h032);
  endtask

  // R9: reset partway through, then a full restart with R6 rounding at 7.5 ns
  task automatic scenarioMidReset;
    @(negedge clk);
    rstN = 1'b0;
    modeVal[1] = 10'h2A5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (160) @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkResetState(1, "R9");
    checkResetState(0, "R9");
    modeVal[1] = 10'h2A5;
    rstN = 1'b1;
    watchSequence(1, 134, 3, 9, 2, 10'h2A5);
  endtask

  bit finished = 0;

  initial begin
    modeVal[0] = 10'h000;
    modeVal[1] = 10'h000;
    scenarioReset();
    scenarioMainSeries();
    scenarioMidReset();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule